// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffer

This block sits beside a first-level cache and keeps several small FIFO prefetch queues, called streams. Each stream follows one run of consecutive line addresses. When the cache misses on a line and no stream has that line at its head, the block hands the least recently used stream to the new run. That stream is flushed, loaded with the lines that follow the missing one, and sends a prefetch request for each of those lines to the next memory level. The next level is pipelined, so many requests can be outstanding at once.

A later cache miss that matches the head of a stream is served from that stream with a hit indication and the line data, so the cache does not wait on memory. The stream then drops that entry and requests the next line in its run. Prefetched lines stay in the streams until a demand miss takes them. Having several streams lets the block follow interleaved access sequences, such as several arrays walked in the same loop.

The memory port tags each request with an identifier that holds a generation count, the stream index and the slot index. This lets responses come back in any order. It also lets a response that belongs to a flushed stream be recognised and thrown away.

Top module: `seqpf_multistream`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `sup_valid` and `mreq_valid` are 0 and `miss_ready` is 1. After reset no stream holds a line, so the first lookup reports a miss.
- R2: A lookup is accepted when `miss_valid` and `miss_ready` are both 1. If the lookup matches no stream head, the cycle after acceptance shows `sup_valid`=1 and `sup_hit`=0, and exactly one stream is reallocated.
- R3: A stream reallocated for line address A requests lines A+1 to A+DEPTH in ascending order. `mreq_id` is {generation[GEN_W-1:0], stream[SW-1:0], slot[PW-1:0]}, with the slot in the low bits. The generation of a stream is 0 after reset and goes up by one on each reallocation, so the first fill of a stream carries generation 1.
- R4: A lookup whose address equals an available head entry is reported the cycle after acceptance with `sup_valid`=1, `sup_hit`=1, and `sup_data` equal to the data the memory returned for that line. The stream then requests the line that follows its last queued line.
- R5: A lookup whose address equals a head entry whose data has not yet returned holds `miss_ready` at 0, and nothing is supplied. It is accepted as a hit in the cycle after the matching response arrives.
- R6: Only the head entry of each stream is compared. A lookup for a line that is queued deeper in a stream is a miss, and it reallocates a stream.
- R7: The stream that is reallocated is the one least recently hit or allocated. Right after reset the order from least to most recent is stream NSTREAM-1 down to stream 0.
- R8: A response whose generation field does not match the current generation of its stream is ignored. A head entry filled by the stream's new run stays unavailable after such a response.
- R9: When several streams have requests waiting, the lowest-numbered stream wins. Within a stream, the slot nearest the head goes first.
- R10: Once `mreq_valid` is 1 while `mreq_ready` is 0, `mreq_valid` stays 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_ready | output | 1 | Lookup may be accepted (low while a matched head waits for data) |
| miss_addr | input | ADDR_W | Line address of the cache miss |
| sup_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| sup_hit | output | 1 | Lookup was served from a stream |
| sup_data | output | DATA_W | Line data supplied on a hit |
| mreq_valid | output | 1 | Prefetch request valid |
| mreq_ready | input | 1 | Next memory level accepts the request |
| mreq_addr | output | ADDR_W | Line address to fetch |
| mreq_id | output | ID_W | Request identifier {generation, stream, slot} |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_id | input | ID_W | Identifier copied from the request |
| mrsp_data | input | DATA_W | Returned line data |

## Verification
The bench answers requests out of order. A design that indexed by arrival order, and not by the slot in the identifier, would supply the wrong line on a hit. It looks up a line that is queued but not at the head. A design that searched every entry would report a hit there and would not reallocate a stream. It holds a lookup on a head whose data is still missing. A design that did not stall would supply stale data, or would miss and flush a useful stream. It replays a late response from a flushed run into the same slot. A design that ignored the generation would mark the new head available with the wrong line. It also blocks the memory port while two streams fill, then releases it, to check that requests are granted by priority and held while blocked.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;

    // Life cycle of one queued line inside a stream.
    typedef enum logic [1:0] {
        ENT_EMPTY = 2'd0,   // slot holds nothing
        ENT_WAIT  = 2'd1,   // tag known, request not yet sent
        ENT_SENT  = 2'd2,   // request sent, data outstanding
        ENT_READY = 2'd3    // data present, may be supplied
    } ent_state_e;

    // Index width for a count of n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fixed_pick.sv
module fixed_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    // Lowest set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/lru_rank.sv
module lru_rank #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         touch,
    input  logic [W-1:0] touch_idx,
    output logic [W-1:0] victim
);
    // Rank 0 is most recent, rank N-1 is the replacement candidate.
    logic [W-1:0] rank [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) rank[i] <= W'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (W'(i) == touch_idx)          rank[i] <= '0;
                else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++)
            if (rank[i] == W'(N - 1)) victim = W'(i);
    end
endmodule

// File: rtl/stream_buf.sv
module stream_buf
    import seqpf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int GEN_W  = 2,
    parameter int PW     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              pop,
    output logic              head_valid,
    output logic              head_avail,
    output logic [ADDR_W-1:0] head_tag,
    output logic [DATA_W-1:0] head_data,
    output logic [GEN_W-1:0]  gen_o,
    output logic              req_valid,
    output logic [PW-1:0]     req_slot,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_take,
    input  logic              rsp_valid,
    input  logic [PW-1:0]     rsp_slot,
    input  logic [GEN_W-1:0]  rsp_gen,
    input  logic [DATA_W-1:0] rsp_data
);
    ent_state_e        st  [DEPTH];
    logic [ADDR_W-1:0] tag [DEPTH];
    logic [DATA_W-1:0] dat [DEPTH];
    logic [PW-1:0]     hp;
    logic [ADDR_W-1:0] nxt;
    logic [GEN_W-1:0]  gen;
    logic [PW-1:0]     hp_inc;

    assign hp_inc     = (hp == PW'(DEPTH - 1)) ? '0 : hp + 1'b1;
    assign head_valid = (st[hp] != ENT_EMPTY);
    assign head_avail = (st[hp] == ENT_READY);
    assign head_tag   = tag[hp];
    assign head_data  = dat[hp];
    assign gen_o      = gen;

    // Oldest unsent slot (nearest the head) is offered first.
    always_comb begin
        int sl;
        req_valid = 1'b0;
        req_slot  = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            sl = (int'(hp) + k) % DEPTH;
            if (st[sl] == ENT_WAIT) begin
                req_valid = 1'b1;
                req_slot  = PW'(sl);
            end
        end
    end
    assign req_addr = tag[req_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st[i]  <= ENT_EMPTY;
                tag[i] <= '0;
                dat[i] <= '0;
            end
            hp  <= '0;
            nxt <= '0;
            gen <= '0;
        end else if (alloc) begin
            // Flush: new run of successive lines, old responses orphaned.
            for (int i = 0; i < DEPTH; i++) begin
                st[i]  <= ENT_WAIT;
                tag[i] <= alloc_addr + ADDR_W'(i + 1);
            end
            hp  <= '0;
            nxt <= alloc_addr + ADDR_W'(DEPTH + 1);
            gen <= gen + 1'b1;
        end else begin
            if (rsp_valid && rsp_gen == gen && st[rsp_slot] == ENT_SENT) begin
                st[rsp_slot]  <= ENT_READY;
                dat[rsp_slot] <= rsp_data;
            end
            if (req_take)
                st[req_slot] <= ENT_SENT;
            if (pop) begin
                st[hp]  <= ENT_WAIT;
                tag[hp] <= nxt;
                nxt     <= nxt + 1'b1;
                hp      <= hp_inc;
            end
        end
    end
endmodule

// File: rtl/seqpf_multistream.sv
module seqpf_multistream
    import seqpf_pkg::*;
#(
    parameter int NSTREAM = 4,
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int GEN_W   = 2,
    localparam int SW     = idx_w(NSTREAM),
    localparam int PW     = idx_w(DEPTH),
    localparam int ID_W   = GEN_W + SW + PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              sup_valid,
    output logic              sup_hit,
    output logic [DATA_W-1:0] sup_data,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [ID_W-1:0]   mreq_id,
    input  logic              mrsp_valid,
    input  logic [ID_W-1:0]   mrsp_id,
    input  logic [DATA_W-1:0] mrsp_data
);
    logic [NSTREAM-1:0] head_valid, head_avail, hit_v, sreq_v;
    logic [NSTREAM-1:0] pop_v, alloc_v, grant_v;
    logic [ADDR_W-1:0]  head_tag  [NSTREAM];
    logic [DATA_W-1:0]  head_data [NSTREAM];
    logic [GEN_W-1:0]   sgen      [NSTREAM];
    logic [PW-1:0]      sreq_slot [NSTREAM];
    logic [ADDR_W-1:0]  sreq_addr [NSTREAM];

    logic          hit_any, req_any, accept;
    logic [SW-1:0] hit_idx, req_idx, victim, touch_idx, rsp_str;
    logic [PW-1:0] rsp_slot;
    logic [GEN_W-1:0] rsp_gen;

    assign rsp_slot = mrsp_id[PW-1:0];
    assign rsp_str  = mrsp_id[PW +: SW];
    assign rsp_gen  = mrsp_id[PW + SW +: GEN_W];

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        assign hit_v[s] = head_valid[s] && (head_tag[s] == miss_addr);
        stream_buf #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
            .GEN_W(GEN_W), .PW(PW)
        ) u_sb (
            .clk        (clk),
            .rst        (rst),
            .alloc      (alloc_v[s]),
            .alloc_addr (miss_addr),
            .pop        (pop_v[s]),
            .head_valid (head_valid[s]),
            .head_avail (head_avail[s]),
            .head_tag   (head_tag[s]),
            .head_data  (head_data[s]),
            .gen_o      (sgen[s]),
            .req_valid  (sreq_v[s]),
            .req_slot   (sreq_slot[s]),
            .req_addr   (sreq_addr[s]),
            .req_take   (grant_v[s]),
            .rsp_valid  (mrsp_valid && (rsp_str == SW'(s))),
            .rsp_slot   (rsp_slot),
            .rsp_gen    (rsp_gen),
            .rsp_data   (mrsp_data)
        );
    end

    fixed_pick #(.N(NSTREAM), .W(SW)) u_hit_pick (
        .vec(hit_v), .any(hit_any), .idx(hit_idx)
    );
    fixed_pick #(.N(NSTREAM), .W(SW)) u_req_pick (
        .vec(sreq_v), .any(req_any), .idx(req_idx)
    );
    lru_rank #(.N(NSTREAM), .W(SW)) u_lru (
        .clk(clk), .rst(rst), .touch(accept),
        .touch_idx(touch_idx), .victim(victim)
    );

    // A matched head without data holds the lookup off.
    assign miss_ready = !(hit_any && !head_avail[hit_idx]);
    assign accept     = miss_valid && miss_ready;
    assign touch_idx  = hit_any ? hit_idx : victim;

    always_comb begin
        pop_v   = '0;
        alloc_v = '0;
        grant_v = '0;
        if (accept) begin
            if (hit_any) pop_v[hit_idx]  = 1'b1;
            else         alloc_v[victim] = 1'b1;
        end
        if (req_any && mreq_ready) grant_v[req_idx] = 1'b1;
    end

    assign mreq_valid = req_any;
    assign mreq_addr  = sreq_addr[req_idx];
    assign mreq_id    = {sgen[req_idx], req_idx, sreq_slot[req_idx]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sup_valid <= 1'b0;
            sup_hit   <= 1'b0;
            sup_data  <= '0;
        end else begin
            sup_valid <= accept;
            sup_hit   <= accept && hit_any;
            if (accept && hit_any) sup_data <= head_data[hit_idx];
        end
    end
endmodule

// File: rtl/seqpf_multistream_chk.sv
module seqpf_multistream_chk #(
    parameter int NSTREAM = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               miss_valid,
    input logic               miss_ready,
    input logic               sup_valid,
    input logic               sup_hit,
    input logic               mreq_valid,
    input logic               mreq_ready,
    input logic [NSTREAM-1:0] pop_v,
    input logic [NSTREAM-1:0] alloc_v
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sup_valid && !mreq_valid && miss_ready));

    p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({pop_v, alloc_v}) <= 1);

    p_supply_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        sup_valid |-> $past(miss_valid && miss_ready));

    p_hit_implies_valid_r4: assert property (@(posedge clk) disable iff (rst)
        sup_hit |-> sup_valid);

    p_stall_no_supply_r5: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !miss_ready) |=> !sup_valid);

    p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> mreq_valid);
endmodule

bind seqpf_multistream seqpf_multistream_chk #(.NSTREAM(NSTREAM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .sup_valid  (sup_valid),
    .sup_hit    (sup_hit),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .pop_v      (pop_v),
    .alloc_v    (alloc_v)
);

// File: tb/tb_seqpf_multistream.sv
`timescale 1ns/1ps
module tb_seqpf_multistream;
    localparam int NS  = 4;
    localparam int D   = 4;
    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int GW  = 2;
    localparam int IDW = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, miss_valid, miss_ready, sup_valid, sup_hit;
    logic mreq_valid, mreq_ready, mrsp_valid;
    logic [AW-1:0] miss_addr, mreq_addr;
    logic [DW-1:0] sup_data, mrsp_data;
    logic [IDW-1:0] mreq_id, mrsp_id;

    seqpf_multistream #(.NSTREAM(NS), .DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .GEN_W(GW)) dut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_addr(miss_addr), .sup_valid(sup_valid), .sup_hit(sup_hit),
        .sup_data(sup_data), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_addr(mreq_addr), .mreq_id(mreq_id), .mrsp_valid(mrsp_valid),
        .mrsp_id(mrsp_id), .mrsp_data(mrsp_data)
    );

    int total = 0, bad = 0;
    bit done = 0;

    logic [AW-1:0]  rq_addr [512];
    logic [IDW-1:0] rq_id   [512];
    int  nreq = 0;
    bit  acc_seen;

    // bench model: head address per stream, use time for LRU, generation
    logic [AW-1:0] sbase [NS];
    bit            sval  [NS];
    int            used  [NS];
    int            gen   [NS];
    int            tick = 1;

    function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    function automatic int lru_victim();
        int v = 0;
        for (int i = 1; i < NS; i++) if (used[i] < used[v]) v = i;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (mreq_valid && mreq_ready && nreq < 512) begin
            rq_addr[nreq] = mreq_addr;
            rq_id[nreq]   = mreq_id;
            nreq++;
        end
        acc_seen = miss_valid && miss_ready;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // lookup with expectation taken from the bench model
    task automatic lookup(input logic [AW-1:0] a, input string tag);
        int hs = -1;
        int guard = 0;
        for (int s = NS - 1; s >= 0; s--) if (sval[s] && sbase[s] == a) hs = s;
        miss_valid = 1'b1;
        miss_addr  = a;
        do begin cyc(); guard++; end while (!acc_seen && guard < 60);
        miss_valid = 1'b0;
        chk({tag, " sup_valid"}, 64'(sup_valid), 64'd1);
        if (hs >= 0) begin
            chk({tag, " hit"}, 64'(sup_hit), 64'd1);
            chk({tag, " data"}, 64'(sup_data), 64'(dfun(a)));
            sbase[hs] = a + 1'b1;
            used[hs]  = tick++;
        end else begin
            int v = lru_victim();
            chk({tag, " miss"}, 64'(sup_hit), 64'd0);
            sval[v]  = 1'b1;
            sbase[v] = a + 1'b1;
            gen[v]   = (gen[v] + 1) % (1 << GW);
            used[v]  = tick++;
        end
    endtask

    task automatic respond_idx(input int i, input logic [DW-1:0] d);
        mrsp_valid = 1'b1;
        mrsp_id    = rq_id[i];
        mrsp_data  = d;
        cyc();
        mrsp_valid = 1'b0;
    endtask

    function automatic int find_req(input logic [AW-1:0] a, input int s);
        int r = -1;
        for (int i = 0; i < nreq; i++)
            if (rq_addr[i] == a && int'(rq_id[i][3:2]) == s) r = i;
        return r;
    endfunction

    task automatic respond(input logic [AW-1:0] a, input int s);
        int i = find_req(a, s);
        chk("request logged", 64'(i >= 0), 64'd1);
        if (i >= 0) respond_idx(i, dfun(a));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n0, v2, va, vb, lo, hi, stale;
        logic [AW-1:0] ba, bb, blo, bhi;
        for (int i = 0; i < NS; i++) begin
            sval[i] = 1'b0; used[i] = -i; gen[i] = 0; sbase[i] = '0;
        end
        rst = 1'b1; miss_valid = 1'b0; miss_addr = '0; mreq_ready = 1'b0;
        mrsp_valid = 1'b0; mrsp_id = '0; mrsp_data = '0;
        idle(3);
        rst = 1'b0;
        #0;
        // R1: idle outputs after reset
        chk("R1 miss_ready", 64'(miss_ready), 64'd1);
        chk("R1 sup_valid", 64'(sup_valid), 64'd0);
        chk("R1 mreq_valid", 64'(mreq_valid), 64'd0);
        mreq_ready = 1'b1;

        // R2/R7: first miss goes to stream NS-1; R3 requests follow
        n0 = nreq;
        lookup(16'h0100, "R2 first miss");
        idle(6);
        chk("R3 request count", 64'(nreq - n0), 64'(D));
        for (int k = 0; k < D; k++) begin
            chk("R3 addr", 64'(rq_addr[n0 + k]), 64'(16'h0101 + k));
            chk("R7 reset-order victim", 64'(rq_id[n0 + k][3:2]), 64'(NS - 1));
            chk("R3 gen field", 64'(rq_id[n0 + k][5:4]), 64'd1);
            chk("R9 slot order", 64'(rq_id[n0 + k][1:0]), 64'(k));
        end
        // out of order responses
        for (int k = D - 1; k >= 0; k--) respond_idx(n0 + k, dfun(16'h0101 + k));

        // R4: head hit then one more request
        n0 = nreq;
        lookup(16'h0101, "R4 head hit");
        idle(3);
        chk("R4 refill count", 64'(nreq - n0), 64'd1);
        chk("R4 refill addr", 64'(rq_addr[n0]), 64'h0105);
        chk("R4 refill stream", 64'(rq_id[n0][3:2]), 64'(NS - 1));

        // R6: deeper entry does not hit; R7 victim by recency
        v2 = lru_victim();
        chk("R7 model victim", 64'(v2), 64'd2);
        n0 = nreq;
        lookup(16'h0103, "R6 non-head lookup");
        idle(6);
        chk("R6 realloc count", 64'(nreq - n0), 64'(D));
        chk("R6 realloc first addr", 64'(rq_addr[n0]), 64'h0104);
        chk("R7 realloc stream", 64'(rq_id[n0][3:2]), 64'(v2));

        // R5: stall on head without data
        miss_valid = 1'b1;
        miss_addr  = 16'h0104;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R5 stall ready", 64'(miss_ready), 64'd0);
            chk("R5 stall no supply", 64'(sup_valid), 64'd0);
        end
        respond(16'h0104, v2);
        chk("R5 ready after data", 64'(miss_ready), 64'd1);
        lookup(16'h0104, "R5 hit after stall");

        // R8: reallocate v2 while its runs are outstanding
        for (int k = 0; k < NS && lru_victim() != v2; k++)
            lookup(16'h1000 + 16'(k * 16'h0100), "R2 filler miss");
        chk("R8 target is victim", 64'(lru_victim()), 64'(v2));
        stale = find_req(16'h0108, v2);
        lookup(16'h2000, "R8 realloc");
        idle(8);
        chk("R8 stale found", 64'(stale >= 0), 64'd1);
        chk("R8 stale slot 0", 64'(rq_id[stale][1:0]), 64'd0);
        if (stale >= 0) respond_idx(stale, dfun(16'h2001));
        miss_valid = 1'b1;
        miss_addr  = 16'h2001;
        #0;
        chk("R8 stale ignored", 64'(miss_ready), 64'd0);
        cyc();
        miss_valid = 1'b0;
        chk("R8 no supply", 64'(sup_valid), 64'd0);
        respond(16'h2001, v2);
        lookup(16'h2001, "R8 fresh data hit");
        idle(4);

        // R9/R10: blocked port, two new streams, priority after release
        mreq_ready = 1'b0;
        va = lru_victim();
        ba = 16'h3000;
        lookup(ba, "R2 alloc a");
        vb = lru_victim();
        bb = 16'h4000;
        lookup(bb, "R2 alloc b");
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R10 held valid", 64'(mreq_valid), 64'd1);
        end
        lo  = (va < vb) ? va : vb;
        hi  = (va < vb) ? vb : va;
        blo = (va < vb) ? ba : bb;
        bhi = (va < vb) ? bb : ba;
        n0 = nreq;
        mreq_ready = 1'b1;
        idle(12);
        chk("R9 count", 64'(nreq - n0), 64'(2 * D));
        for (int k = 0; k < D; k++) begin
            chk("R9 low stream first", 64'(rq_id[n0 + k][3:2]), 64'(lo));
            chk("R9 low addr", 64'(rq_addr[n0 + k]), 64'(blo + 16'(k + 1)));
            chk("R9 high stream next", 64'(rq_id[n0 + D + k][3:2]), 64'(hi));
            chk("R9 high addr", 64'(rq_addr[n0 + D + k]), 64'(bhi + 16'(k + 1)));
        end
        chk("R3 gen after realloc", 64'(rq_id[n0][5:4]), 64'(gen[lo]));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule